// File: doc/BRIEF.md
# Serial Control-Register Slave

This block lets a host processor load and inspect a small bank of 8-bit control registers over a two-wire serial bus (an I2C-compatible clock line and data line). Both bus lines are oversampled by a much faster system clock, passed through synchronizers, and turned into clock-edge, START and STOP events. The slave answers only to its fixed 7-bit device address. It acknowledges by enabling an open-drain pull-down on the data line.

A write frame carries a device address byte with the direction bit clear, a register index byte and exactly one data byte. The data byte lands in the indexed register. The index byte also sets a read pointer that stays after the frame ends. A read frame carries a device address byte with the direction bit set. The slave then shifts out the register at the pointer, most significant bit first. A host usually sends a write frame holding only the index, then a repeated START and a read frame. All register contents appear side by side on one flat output bus that feeds the downstream control logic.

The system clock must run at least sixteen times faster than the serial clock.

Top module: `ctlRegSlave`

## Requirements
- R1: After reset every register reads zero on `regFlat` and `sdaOe` is low (data line released).
- R2: A START (data falling while clock high) opens a frame. If the first byte holds device address 7'b0001000 in its upper seven bits, the slave acknowledges it. Bit 0 of that byte selects write (0) or read (1). A STOP (data rising while clock high) releases the data line.
- R3: When the address bits do not match, the slave acknowledges neither that byte nor any later byte of the frame, and no register changes.
- R4: An acknowledge holds `sdaOe` high over the whole high period of the ninth clock of the byte. It is released within a few system clocks after that clock falls.
- R5: In a write frame the second byte is a register index n and the third byte is stored in register n. Register n drives `regFlat[8n+7:8n]`, for n from 0 to 9.
- R6: A write to an index above 9 is acknowledged (index and data bytes), and no register changes.
- R7: Only one data byte is accepted per frame. Further bytes before STOP are not acknowledged and change nothing.
- R8: In a read frame the slave drives the register selected by the last received index byte, MSB first, one bit for each clock. If that index is above 9, it returns 8'h00.
- R9: A repeated START without a STOP begins a new frame. The index loaded before it remains valid for a following read.
- R10: A START or STOP that arrives before the data byte is complete ends the frame, and no register is updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| regFlat | output | 80 | Register contents, register n at bits [8n+7:8n] |

## Verification
A frame state that has slipped by one bit shows up at the ninth clock of that byte. The acknowledge either goes missing or lands on a data bit, so the host sees it within one byte time. A wrong index or pointer is visible on `regFlat` as soon as the STOP ends the frame, or on the data line during the next read byte. A missed abort, a commit outside its place, or a write past the top index shows up on `regFlat` immediately after the frame. The bench reads the whole bus there after each scenario.

// File: rtl/regSlavePkg.sv
package regSlavePkg;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACKDEV, ST_REG, ST_ACKREG,
    ST_DATA, ST_ACKDATA, ST_READ, ST_READACK, ST_SKIP
  } ctlState_t;

endpackage

// File: rtl/busSync.sv
module busSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sclPipe;
  logic [DEPTH-1:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[DEPTH-2:0], sclIn};
      sdaPipe <= {sdaPipe[DEPTH-2:0], sdaIn};
    end
  end

  logic sclPrev, sdaPrev;
  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclPrev  = sclPipe[STAGES];
  assign sdaPrev  = sdaPipe[STAGES];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/slaveCtl.sv
module slaveCtl
  import regSlavePkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0001000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclLvl,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  output dpStrobe_t str,
  output logic      sdaOe
);
  ctlState_t state, nState;
  logic [2:0] cnt, nCnt;
  logic phase, nPhase;
  logic rw, nRw;
  logic ackDrive, nAck;
  logic txOn, nTx;

  always_comb begin
    nState = state;
    nCnt   = cnt;
    nPhase = phase;
    nRw    = rw;
    nAck   = ackDrive;
    nTx    = txOn;
    str    = '0;
    if (stopDet) begin
      nState = ST_IDLE;
      nAck   = 1'b0;
      nTx    = 1'b0;
    end else if (startDet) begin
      nState = ST_DEV;
      nCnt   = 3'd0;
      nAck   = 1'b0;
      nTx    = 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_REG, ST_DATA: begin
          if (sclRise) begin
            str.shiftIn = 1'b1;
            nCnt = cnt + 3'd1;
            if (cnt == 3'd7) begin
              nPhase = 1'b0;
              nState = (state == ST_DEV) ? ST_ACKDEV :
                       (state == ST_REG) ? ST_ACKREG : ST_ACKDATA;
            end
          end
        end
        ST_ACKDEV: begin
          if (sclFall) begin
            if (!phase) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                nAck   = 1'b1;
                nRw    = rxByte[0];
                nPhase = 1'b1;
              end else begin
                nState = ST_SKIP;
              end
            end else begin
              nAck = 1'b0;
              nCnt = 3'd0;
              if (rw) begin
                nState     = ST_READ;
                nTx        = 1'b1;
                str.loadTx = 1'b1;
              end else begin
                nState = ST_REG;
              end
            end
          end
        end
        ST_ACKREG: begin
          if (sclFall) begin
            if (!phase) begin
              nAck        = 1'b1;
              str.loadPtr = 1'b1;
              nPhase      = 1'b1;
            end else begin
              nAck   = 1'b0;
              nCnt   = 3'd0;
              nState = ST_DATA;
            end
          end
        end
        ST_ACKDATA: begin
          if (sclFall) begin
            if (!phase) begin
              nAck         = 1'b1;
              str.writeReg = 1'b1;
              nPhase       = 1'b1;
            end else begin
              nAck   = 1'b0;
              nState = ST_SKIP;
            end
          end
        end
        ST_READ: begin
          if (sclFall) begin
            nCnt = cnt + 3'd1;
            if (cnt == 3'd7) begin
              nTx    = 1'b0;
              nState = ST_READACK;
            end else begin
              str.shiftTx = 1'b1;
            end
          end
        end
        ST_READACK: if (sclFall) nState = ST_SKIP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= 3'd0;
      phase    <= 1'b0;
      rw       <= 1'b0;
      ackDrive <= 1'b0;
      txOn     <= 1'b0;
    end else begin
      state    <= nState;
      cnt      <= nCnt;
      phase    <= nPhase;
      rw       <= nRw;
      ackDrive <= nAck;
      txOn     <= nTx;
    end
  end

  assign sdaOe = ackDrive | (txOn & ~txMsb);

  assert_ack_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && !startDet && !stopDet) |=> $stable(ackDrive));

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!ackDrive && !txOn));

  assert_no_ack_mismatch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKDEV && sclFall && !phase && !startDet && !stopDet &&
     rxByte[7:1] != DEV_ADDR) |=> !ackDrive);

  assert_single_driver_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackDrive, txOn}));

endmodule

// File: rtl/regBank.sv
module regBank
  import regSlavePkg::*;
#(
  parameter int NREG = 10,
  parameter int DW   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaBit,
  input  dpStrobe_t        str,
  output logic [DW-1:0]    rxByte,
  output logic             txMsb,
  output logic [NREG*DW-1:0] regFlat
);
  localparam int IDXW = $clog2(NREG);
  localparam logic [DW-1:0] LAST = DW'(NREG - 1);

  logic [DW-1:0] rxShift, txShift, ptr;
  logic [DW-1:0] regFile [NREG];
  logic ptrOk;

  assign ptrOk = (ptr <= LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
    end else begin
      if (str.shiftIn) rxShift <= {rxShift[DW-2:0], sdaBit};
      if (str.loadPtr) ptr <= rxShift;
      if (str.loadTx)  txShift <= ptrOk ? regFile[ptr[IDXW-1:0]] : '0;
      else if (str.shiftTx) txShift <= {txShift[DW-2:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (str.writeReg && ptrOk && ptr[IDXW-1:0] == IDXW'(g))
        regFile[g] <= rxShift;
    end
    assign regFlat[g*DW +: DW] = regFile[g];
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[DW-1];

  assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !str.writeReg |=> $stable(regFlat));

  assert_discard_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (str.writeReg && !ptrOk) |=> $stable(regFlat));

endmodule

// File: rtl/ctlRegSlave.sv
module ctlRegSlave
  import regSlavePkg::*;
#(
  parameter int         NREG     = 10,
  parameter int         DW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'b0001000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  output logic [NREG*DW-1:0] regFlat
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [DW-1:0] rxByte;
  logic txMsb;
  dpStrobe_t str;

  busSync #(.STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  slaveCtl #(.DEV_ADDR(DEV_ADDR)) uCtl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txMsb(txMsb), .str(str), .sdaOe(sdaOe)
  );

  regBank #(.NREG(NREG), .DW(DW)) uBank (
    .clk(clk), .rstN(rstN), .sdaBit(sdaLvl), .str(str),
    .rxByte(rxByte), .txMsb(txMsb), .regFlat(regFlat)
  );

endmodule

// File: tb/sim_ctlRegSlave.sv
module sim_ctlRegSlave;
  localparam int QCYC = 8;
  localparam int NREG = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic sdaBus;
  logic [NREG*8-1:0] regFlat;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [NREG];

  always #2 clk = ~clk;
  assign sdaBus = sdaDrv & ~sdaOe;

  ctlRegSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .regFlat(regFlat)
  );

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] modelFlat();
    logic [79:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic checkRegs(input string tag);
    check(regFlat === modelFlat(), tag, regFlat, modelFlat());
  endtask

  task automatic waitQ();
    repeat (QCYC) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; waitQ();
    sclDrv = 1'b1; waitQ(); waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  // returns ack seen at early and late high, and release after the ninth clock
  task automatic sendByte(input logic [7:0] b, output logic ackEarly, output logic ackLate, output logic released);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1;
    repeat (2) @(posedge clk);
    #1 ackEarly = ~sdaBus;
    repeat (2*QCYC - 3) @(posedge clk);
    #1 ackLate = ~sdaBus;
    repeat (1) @(posedge clk);
    #1 sclDrv = 1'b0;
    waitQ();
    released = ~sdaOe;
  endtask

  task automatic recvByte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = 1'b1; waitQ();
      sclDrv = 1'b1; waitQ();
      d[i] = sdaBus; waitQ();
      sclDrv = 1'b0; waitQ();
    end
    sendBit(1'b1);
  endtask

  task automatic writeFrame(input logic [7:0] idx, input logic [7:0] val, output logic allAck);
    logic e, l, r;
    allAck = 1'b1;
    busStart();
    sendByte(8'h10, e, l, r); allAck &= e & l;
    sendByte(idx, e, l, r);   allAck &= e & l;
    sendByte(val, e, l, r);   allAck &= e & l;
    busStop();
    if (idx < NREG) model[idx] = val;
  endtask

  task automatic testReset();
    check(regFlat === '0, "R1 regs zero after reset", regFlat, '0);
    check(sdaOe === 1'b0, "R1 data line released after reset", {79'b0, sdaOe}, '0);
  endtask

  task automatic testWriteOne();
    logic e, l, r;
    busStart();
    sendByte(8'h10, e, l, r);
    check(e & l, "R2 device address acknowledged", {78'b0, e, l}, 80'h3);
    sendByte(8'h02, e, l, r);
    check(e & l & r, "R4 ack held over ninth high and released", {77'b0, e, l, r}, 80'h7);
    sendByte(8'hA5, e, l, r);
    busStop();
    model[2] = 8'hA5;
    check(sdaOe === 1'b0, "R2 released after STOP", {79'b0, sdaOe}, '0);
    checkRegs("R5 single write lands at index 2");
  endtask

  task automatic testWrongAddr();
    logic e, l, r;
    busStart();
    sendByte(8'h12, e, l, r);
    check(!e && !l, "R3 mismatched address not acknowledged", {78'b0, e, l}, '0);
    sendByte(8'h02, e, l, r);
    check(!e && !l, "R3 later byte not acknowledged", {78'b0, e, l}, '0);
    sendByte(8'h11, e, l, r);
    busStop();
    checkRegs("R3 registers unchanged after foreign frame");
  endtask

  task automatic testHighIndex();
    logic ok;
    writeFrame(8'h0C, 8'hFF, ok);
    check(ok, "R6 high index frame acknowledged", {79'b0, ok}, 80'h1);
    checkRegs("R6 high index write discarded");
  endtask

  task automatic testExtra();
    logic e, l, r;
    busStart();
    sendByte(8'h10, e, l, r);
    sendByte(8'h03, e, l, r);
    sendByte(8'h5A, e, l, r);
    sendByte(8'hFF, e, l, r);
    check(!e && !l, "R7 second data byte not acknowledged", {78'b0, e, l}, '0);
    busStop();
    model[3] = 8'h5A;
    checkRegs("R7 register keeps first data byte");
  endtask

  task automatic testAll();
    logic ok;
    for (int i = 0; i < NREG; i++) writeFrame(8'(i), 8'(i * 8'h13 + 8'h21), ok);
    checkRegs("R5 all ten registers at their bit positions");
  endtask

  task automatic testRead();
    logic ok, e, l, r;
    logic [7:0] d;
    writeFrame(8'h07, 8'h3C, ok);
    busStart();
    sendByte(8'h11, e, l, r);
    check(e & l, "R8 read address acknowledged", {78'b0, e, l}, 80'h3);
    recvByte(d);
    busStop();
    check(d === 8'h3C, "R8 read returns last written index", {72'b0, d}, 80'h3C);
    busStart();
    sendByte(8'h10, e, l, r);
    sendByte(8'h02, e, l, r);
    busStart();
    sendByte(8'h11, e, l, r);
    recvByte(d);
    busStop();
    check(d === model[2], "R9 repeated START read uses loaded index", {72'b0, d}, {72'b0, model[2]});
    busStart();
    sendByte(8'h10, e, l, r);
    sendByte(8'h0C, e, l, r);
    busStart();
    sendByte(8'h11, e, l, r);
    recvByte(d);
    busStop();
    check(d === 8'h00, "R8 read above index 9 returns zero", {72'b0, d}, '0);
  endtask

  task automatic testAbort();
    logic e, l, r;
    busStart();
    sendByte(8'h10, e, l, r);
    sendByte(8'h04, e, l, r);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    checkRegs("R10 STOP mid byte leaves register");
    busStart();
    sendByte(8'h10, e, l, r);
    sendByte(8'h05, e, l, r);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    busStart();
    checkRegs("R10 START mid byte leaves register");
    sendByte(8'h10, e, l, r);
    sendByte(8'h06, e, l, r);
    sendByte(8'h77, e, l, r);
    busStop();
    model[6] = 8'h77;
    checkRegs("R9 frame after repeated START is written");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testWriteOne();
    testWrongAddr();
    testHighIndex();
    testExtra();
    testAll();
    testRead();
    testAbort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule